// File: doc/BRIEF.md
# Trace Resource Selector Array

This block holds a bank of programmable selectors for an event-trace unit. Each selector picks a set of signals from one resource group and reduces them to a single boolean. The groups are external inputs, processing-element comparator inputs, counters at zero together with sequencer states, single-shot comparator controls, single address comparators, address range comparators, context identifier comparators and virtual context identifier comparators. After the reduction, an optional per-selector inversion is applied. Selectors work in even/odd pairs. Each pair also produces a combined result, and an invert bit held only in the even member can flip that result.

Selectors 0 and 1 are fixed at false and true. Selectors 2 and up are programmed through a simple write/read port indexed by selector number. Writes take effect only while the trace unit reports idle. All results are registered, so an output reflects the resources and the configuration that were present on the clock edge before it.

Top module: `trace_rsel_array`

## Requirements
- R1: `sel_out[0]` is always 0 and `sel_out[1]` is always 1, including during reset. Writes to indices 0 and 1 are ignored, and reads of those indices return 0.
- R2: After reset every control word reads 0, every programmable selector outputs 0 and every pair output is 0.
- R3: The control word format is: mask in bits [15:0], group in bits [19:16], own invert in bit [20], pair invert in bit [21].
- R4: The group codes are 0 external, 1 comparator inputs, 2 counters/sequencer, 3 single-shot, 4 single address, 5 address range, 6 context ID and 7 virtual context ID. On the clock edge, `sel_out[i]` is loaded with the OR of (mask AND the chosen group's resource vector), exclusive-ORed with the own-invert bit. The configuration used is the one in force before that edge.
- R5: An empty mask, or a group code from 8 to 15, gives a raw result of 0. The output then equals the own-invert bit.
- R6: Setting the own-invert bit inverts that selector's output.
- R7: `pair_out[p]` is loaded on each edge with (post-invert output of selector 2p AND post-invert output of selector 2p+1), exclusive-ORed with the pair-invert bit of selector 2p. On odd selectors, bit 21 is stored as 0 and has no effect.
- R8: A write issued while `idle` is low leaves the register unchanged.
- R9: Bits 31:22 read as 0. Mask bits outside the written group's field width, or at or above its implemented count, are stored as 0. The default counts are 3 external, 8 comparator, 2 counters, 4 sequencer states, 8 single-shot, 16 single address, 8 range, 4 context ID and 8 virtual context ID. The field widths are 4, 8, 4+4, 8, 16, 8, 8 and 8 bits.
- R10: In group 2, mask bits [3:0] select "counter m is zero" (`cnt_zero[m]`) and mask bits [7:4] select "sequencer in state m" (`seq_st[m]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle | input | 1 | Trace unit idle; writes accepted only when high |
| wr_en | input | 1 | Control word write strobe |
| wr_idx | input | 5 | Selector index to write |
| wr_data | input | 32 | Control word to write |
| rd_idx | input | 5 | Selector index to read |
| rd_data | output | 32 | Stored control word of `rd_idx` (combinational) |
| ext_in | input | 4 | External input resources |
| pec_in | input | 8 | Comparator input resources |
| cnt_zero | input | 4 | Counter-at-zero flags |
| seq_st | input | 4 | One-hot sequencer state |
| ssc_in | input | 8 | Single-shot comparator controls |
| sac_in | input | 16 | Single address comparator matches |
| arc_in | input | 8 | Address range comparator matches |
| cid_in | input | 8 | Context ID comparator matches |
| vmid_in | input | 8 | Virtual context ID comparator matches |
| sel_out | output | 32 | Registered post-invert result per selector |
| pair_out | output | 16 | Registered combined result per pair |

## Verification
A configuration write and a selector evaluation can land on the same clock edge. The result loaded on that edge must come from the old control word, and the new word must govern only the following edge. The bench provokes this by writing selectors while their groups' resources toggle, in both a directed phase and a long random phase. Writes with `idle` low are mixed into the same traffic. A cycle-level model forms each expectation from the configuration before the write, and the bench compares every output and the read port on every cycle.

// File: rtl/trsel_pkg.sv
`timescale 1ns/1ps
package trsel_pkg;

    localparam int FIELD_W  = 16;
    localparam int NUM_GRP  = 8;
    localparam int GRPVEC_W = NUM_GRP * FIELD_W;
    localparam int WORD_W   = 32;

    typedef enum logic [3:0] {
        GRP_EXT    = 4'd0,
        GRP_PEC    = 4'd1,
        GRP_CNTSEQ = 4'd2,
        GRP_SSC    = 4'd3,
        GRP_SAC    = 4'd4,
        GRP_ARC    = 4'd5,
        GRP_CID    = 4'd6,
        GRP_VMID   = 4'd7
    } grp_code_e;

    typedef struct packed {
        logic                pair_inv;
        logic                inv;
        logic [3:0]          grp;
        logic [FIELD_W-1:0]  mask;
    } sel_cfg_t;

    localparam int CFG_W = $bits(sel_cfg_t);

    function automatic logic [FIELD_W-1:0] low_mask(input int n);
        logic [FIELD_W-1:0] m;
        m = '0;
        for (int b = 0; b < FIELD_W; b++) begin
            if (b < n) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [FIELD_W-1:0] cntseq_mask(input int n_cnt, input int n_seq);
        logic [FIELD_W-1:0] c;
        logic [FIELD_W-1:0] s;
        c = low_mask(n_cnt) & 16'h000F;
        s = low_mask(n_seq) & 16'h000F;
        return c | (s << 4);
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input sel_cfg_t c);
        return {{(WORD_W-CFG_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/trsel_cfg_regs.sv
`timescale 1ns/1ps
module trsel_cfg_regs
    import trsel_pkg::*;
#(
    parameter int NUM_SEL = 32,
    parameter int IDX_W   = 5,
    parameter logic [GRPVEC_W-1:0] IMPL_MASKS = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WORD_W-1:0]    wr_data,
    output sel_cfg_t             cfg [NUM_SEL]
);

    sel_cfg_t           wr_cfg;
    logic [3:0]         wr_grp;
    logic [FIELD_W-1:0] wr_allowed;
    logic               wr_ok;

    assign wr_ok  = wr_en && idle;
    assign wr_grp = wr_data[19:16];

    always_comb begin
        if (wr_grp[3]) wr_allowed = '0;
        else           wr_allowed = IMPL_MASKS[wr_grp[2:0]*FIELD_W +: FIELD_W];
        wr_cfg.mask     = wr_data[15:0] & wr_allowed;
        wr_cfg.grp      = wr_grp;
        wr_cfg.inv      = wr_data[20];
        wr_cfg.pair_inv = wr_data[21];
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_reg
        if (i < 2) begin : g_fixed
            assign cfg[i] = '0;
        end else begin : g_prog
            sel_cfg_t r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else if (wr_ok && wr_idx == IDX_W'(i)) begin
                    r.mask     <= wr_cfg.mask;
                    r.grp      <= wr_cfg.grp;
                    r.inv      <= wr_cfg.inv;
                    r.pair_inv <= (i % 2 == 0) ? wr_cfg.pair_inv : 1'b0;
                end
            end
            assign cfg[i] = r;
        end
    end

endmodule

// File: rtl/trsel_unit.sv
`timescale 1ns/1ps
module trsel_unit
    import trsel_pkg::*;
(
    input  sel_cfg_t              cfg,
    input  logic [GRPVEC_W-1:0]   grp_vec,
    output logic                  post_inv
);

    logic [FIELD_W-1:0] picked;
    logic               raw;

    always_comb begin
        picked   = grp_vec[cfg.grp[2:0]*FIELD_W +: FIELD_W];
        raw      = !cfg.grp[3] && (|(cfg.mask & picked));
        post_inv = raw ^ cfg.inv;
    end

endmodule

// File: rtl/trace_rsel_array.sv
`timescale 1ns/1ps
module trace_rsel_array
    import trsel_pkg::*;
#(
    parameter int NUM_SEL  = 32,
    parameter int NUM_EXT  = 3,
    parameter int NUM_PEC  = 8,
    parameter int NUM_CNT  = 2,
    parameter int NUM_SEQ  = 4,
    parameter int NUM_SSC  = 8,
    parameter int NUM_SAC  = 16,
    parameter int NUM_ARC  = 8,
    parameter int NUM_CID  = 4,
    parameter int NUM_VMID = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     idle,
    input  logic                     wr_en,
    input  logic [4:0]               wr_idx,
    input  logic [31:0]              wr_data,
    input  logic [4:0]               rd_idx,
    output logic [31:0]              rd_data,
    input  logic [3:0]               ext_in,
    input  logic [7:0]               pec_in,
    input  logic [3:0]               cnt_zero,
    input  logic [3:0]               seq_st,
    input  logic [7:0]               ssc_in,
    input  logic [15:0]              sac_in,
    input  logic [7:0]               arc_in,
    input  logic [7:0]               cid_in,
    input  logic [7:0]               vmid_in,
    output logic [NUM_SEL-1:0]       sel_out,
    output logic [NUM_SEL/2-1:0]     pair_out
);

    localparam int IDX_W    = 5;
    localparam int NUM_PAIR = NUM_SEL / 2;
    localparam logic [GRPVEC_W-1:0] IMPL_MASKS = {
        low_mask(NUM_VMID) & 16'h00FF,
        low_mask(NUM_CID)  & 16'h00FF,
        low_mask(NUM_ARC)  & 16'h00FF,
        low_mask(NUM_SAC),
        low_mask(NUM_SSC)  & 16'h00FF,
        cntseq_mask(NUM_CNT, NUM_SEQ),
        low_mask(NUM_PEC)  & 16'h00FF,
        low_mask(NUM_EXT)  & 16'h000F
    };
    localparam logic [NUM_SEL-1:0] SEL_RST = NUM_SEL'(2);

    sel_cfg_t             cfg [NUM_SEL];
    logic [GRPVEC_W-1:0]  grp_vec;
    logic [NUM_SEL-1:0]   sel_nxt;
    logic [NUM_PAIR-1:0]  pair_nxt;

    assign grp_vec = {
        8'h00, vmid_in,
        8'h00, cid_in,
        8'h00, arc_in,
        sac_in,
        8'h00, ssc_in,
        8'h00, seq_st, cnt_zero,
        8'h00, pec_in,
        12'h000, ext_in
    };

    trsel_cfg_regs #(
        .NUM_SEL    (NUM_SEL),
        .IDX_W      (IDX_W),
        .IMPL_MASKS (IMPL_MASKS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .idle    (idle),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    always_comb begin
        if (int'(rd_idx) < NUM_SEL) rd_data = cfg_to_word(cfg[rd_idx]);
        else                        rd_data = '0;
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        if (i == 0) begin : g_false
            assign sel_nxt[i] = 1'b0;
        end else if (i == 1) begin : g_true
            assign sel_nxt[i] = 1'b1;
        end else begin : g_unit
            trsel_unit u_unit (
                .cfg      (cfg[i]),
                .grp_vec  (grp_vec),
                .post_inv (sel_nxt[i])
            );
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pair_nxt[p] = (sel_nxt[2*p] & sel_nxt[2*p+1]) ^ cfg[2*p].pair_inv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_out  <= SEL_RST;
            pair_out <= '0;
        end else begin
            sel_out  <= sel_nxt;
            pair_out <= pair_nxt;
        end
    end

endmodule

// File: rtl/trsel_checker.sv
`timescale 1ns/1ps
module trsel_checker
    import trsel_pkg::*;
#(
    parameter int NUM_SEL = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle,
    input  logic                 wr_en,
    input  logic [4:0]           rd_idx,
    input  logic [31:0]          rd_data,
    input  logic [NUM_SEL-1:0]   sel_out,
    input  logic [NUM_SEL/2-1:0] pair_out,
    input  sel_cfg_t             cfg [NUM_SEL]
);

    AST_FIXED_SELECTORS: assert property (@(posedge clk) disable iff (rst)
        (sel_out[0] == 1'b0) && (sel_out[1] == 1'b1)); // R1

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:22] == 10'd0); // R9

    AST_ODD_NO_PAIRINV: assert property (@(posedge clk) disable iff (rst)
        rd_idx[0] |-> (rd_data[21] == 1'b0)); // R7

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idle) |=> ((rd_idx != $past(rd_idx)) || (rd_data == $past(rd_data)))); // R8

    for (genvar p = 0; p < NUM_SEL/2; p++) begin : g_pchk
        AST_PAIR_COMBINE: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (pair_out[p] == ((sel_out[2*p] & sel_out[2*p+1]) ^ $past(cfg[2*p].pair_inv)))); // R7
    end

    for (genvar i = 2; i < NUM_SEL; i++) begin : g_schk
        AST_EMPTY_GIVES_INV: assert property (@(posedge clk) disable iff (rst)
            ((cfg[i].mask == '0) || cfg[i].grp[3]) |=> (sel_out[i] == $past(cfg[i].inv))); // R5
    end

endmodule

bind trace_rsel_array trsel_checker #(.NUM_SEL(NUM_SEL)) u_trsel_chk (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .wr_en    (wr_en),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .sel_out  (sel_out),
    .pair_out (pair_out),
    .cfg      (cfg)
);

// File: tb/tb_trace_rsel_array.sv
`timescale 1ns/1ps
module tb_trace_rsel_array;

    logic        clk = 1'b0;
    logic        rst;
    logic        idle;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic [3:0]  ext_in;
    logic [7:0]  pec_in;
    logic [3:0]  cnt_zero;
    logic [3:0]  seq_st;
    logic [7:0]  ssc_in;
    logic [15:0] sac_in;
    logic [7:0]  arc_in;
    logic [7:0]  cid_in;
    logic [7:0]  vmid_in;
    logic [31:0] sel_out;
    logic [15:0] pair_out;

    always #10 clk = ~clk;

    trace_rsel_array dut (
        .clk(clk), .rst(rst), .idle(idle), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .ext_in(ext_in), .pec_in(pec_in), .cnt_zero(cnt_zero), .seq_st(seq_st),
        .ssc_in(ssc_in), .sac_in(sac_in), .arc_in(arc_in), .cid_in(cid_in),
        .vmid_in(vmid_in), .sel_out(sel_out), .pair_out(pair_out)
    );

    int          vectors = 0;
    int          misses  = 0;
    string       phase   = "R2";
    logic [31:0] model [32];
    logic [31:0] exp_sel;
    logic [15:0] exp_pair;

    function automatic logic [15:0] allowed(input int g);
        case (g)
            0: return 16'h0007;
            1: return 16'h00FF;
            2: return 16'h00F3;
            3: return 16'h00FF;
            4: return 16'hFFFF;
            5: return 16'h00FF;
            6: return 16'h000F;
            7: return 16'h00FF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] resource(input int g);
        case (g)
            0: return {12'h0, ext_in};
            1: return {8'h0, pec_in};
            2: return {8'h0, seq_st, cnt_zero};
            3: return {8'h0, ssc_in};
            4: return sac_in;
            5: return {8'h0, arc_in};
            6: return {8'h0, cid_in};
            7: return {8'h0, vmid_in};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic eval_one(input int i);
        int g;
        logic hit;
        if (i == 0) return 1'b0;
        if (i == 1) return 1'b1;
        g   = int'(model[i][19:16]);
        hit = (|(model[i][15:0] & resource(g)));
        return hit ^ model[i][20];
    endfunction

    task automatic report(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic print_summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // one cycle: drive at negedge, check read port, predict edge, apply write to model, check at next negedge
    task automatic step(input logic we, input logic id, input int wi, input logic [31:0] wd, input int ri);
        wr_en   = we;
        idle    = id;
        wr_idx  = 5'(wi);
        wr_data = wd;
        rd_idx  = 5'(ri);
        #1;
        report("rd_data", rd_data, model[ri]);
        for (int i = 0; i < 32; i++) exp_sel[i] = eval_one(i);
        for (int p = 0; p < 16; p++)
            exp_pair[p] = (exp_sel[2*p] & exp_sel[2*p+1]) ^ model[2*p][21];
        if (we && id && wi >= 2) begin
            logic [31:0] w;
            int g;
            g = int'(wd[19:16]);
            w = 32'h0;
            w[15:0]  = wd[15:0] & allowed(g);
            w[19:16] = wd[19:16];
            w[20]    = wd[20];
            w[21]    = (wi % 2 == 0) ? wd[21] : 1'b0;
            model[wi] = w;
        end
        @(negedge clk);
        report("sel_out", sel_out, exp_sel);
        report("pair_out", {16'h0, pair_out}, {16'h0, exp_pair});
    endtask

    task automatic idle_cyc(input int ri);
        step(1'b0, 1'b1, 0, 32'h0, ri);
    endtask

    task automatic set_res(input logic [3:0] e, input logic [7:0] pc, input logic [3:0] cz,
                           input logic [3:0] sq, input logic [15:0] sa);
        ext_in = e; pec_in = pc; cnt_zero = cz; seq_st = sq; sac_in = sa;
    endtask

    function automatic logic [31:0] word(input logic pinv, input logic inv, input int g, input logic [15:0] m);
        return {10'h0, pinv, inv, 4'(g), m};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired in phase %s actual running expected done", phase);
        print_summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        rst = 1'b1; idle = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
        set_res(4'h0, 8'h0, 4'h0, 4'h0, 16'h0);
        ssc_in = '0; arc_in = '0; cid_in = '0; vmid_in = '0;
        repeat (3) @(negedge clk);
        phase = "R1 during reset";
        report("sel_out", sel_out, 32'h0000_0002);
        rst = 1'b0;
        @(negedge clk);

        phase = "R2 reset state";
        report("sel_out", sel_out, 32'h0000_0002);
        report("pair_out", {16'h0, pair_out}, 32'h0);
        set_res(4'hF, 8'hFF, 4'hF, 4'hF, 16'hFFFF);
        for (int i = 0; i < 32; i++) idle_cyc(i);

        phase = "R1 fixed selectors";
        step(1'b1, 1'b1, 0, word(1'b1, 1'b1, 0, 16'hF), 0);
        step(1'b1, 1'b1, 1, word(1'b0, 1'b1, 0, 16'hF), 1);
        idle_cyc(1);

        phase = "R3 R4 field layout and OR reduction";
        set_res(4'h0, 8'h0, 4'h0, 4'h0, 16'h0);
        step(1'b1, 1'b1, 2, word(1'b0, 1'b0, 0, 16'h0003), 2);
        idle_cyc(2);
        ext_in = 4'h2; idle_cyc(2);
        ext_in = 4'h4; idle_cyc(2);
        step(1'b1, 1'b1, 4, word(1'b0, 1'b0, 4, 16'h8000), 4);
        sac_in = 16'h8000; idle_cyc(4);
        sac_in = 16'h7FFF; idle_cyc(4);
        step(1'b1, 1'b1, 5, word(1'b0, 1'b0, 1, 16'h0080), 5);
        pec_in = 8'h80; idle_cyc(5);

        phase = "R10 counters and sequencer";
        step(1'b1, 1'b1, 6, word(1'b0, 1'b0, 2, 16'h0001), 6);
        cnt_zero = 4'h1; idle_cyc(6);
        cnt_zero = 4'h0; idle_cyc(6);
        step(1'b1, 1'b1, 7, word(1'b0, 1'b0, 2, 16'h0040), 7);
        seq_st = 4'h4; idle_cyc(7);
        seq_st = 4'h2; idle_cyc(7);

        phase = "R5 empty mask and reserved group";
        set_res(4'hF, 8'hFF, 4'hF, 4'hF, 16'hFFFF);
        step(1'b1, 1'b1, 8, word(1'b0, 1'b0, 4, 16'h0000), 8);
        idle_cyc(8);
        step(1'b1, 1'b1, 9, word(1'b0, 1'b0, 12, 16'hFFFF), 9);
        idle_cyc(9);
        step(1'b1, 1'b1, 9, word(1'b0, 1'b1, 9, 16'hFFFF), 9);
        idle_cyc(9);

        phase = "R6 own invert";
        step(1'b1, 1'b1, 10, word(1'b0, 1'b1, 0, 16'h0001), 10);
        ext_in = 4'h1; idle_cyc(10);
        ext_in = 4'h0; idle_cyc(10);

        phase = "R7 pair combine and pair invert";
        step(1'b1, 1'b1, 12, word(1'b0, 1'b0, 0, 16'h0001), 12);
        step(1'b1, 1'b1, 13, word(1'b1, 1'b0, 0, 16'h0002), 13);
        ext_in = 4'h3; idle_cyc(13);
        ext_in = 4'h1; idle_cyc(12);
        step(1'b1, 1'b1, 12, word(1'b1, 1'b0, 0, 16'h0001), 12);
        ext_in = 4'h3; idle_cyc(12);
        ext_in = 4'h2; idle_cyc(13);

        phase = "R8 writes while busy";
        step(1'b1, 1'b0, 14, word(1'b1, 1'b1, 4, 16'hFFFF), 14);
        idle_cyc(14);
        step(1'b1, 1'b0, 2, word(1'b0, 1'b1, 0, 16'h0000), 2);
        idle_cyc(2);

        phase = "R9 reserved and unimplemented bits";
        step(1'b1, 1'b1, 15, 32'hFFFF_FFFF, 15);
        idle_cyc(15);
        step(1'b1, 1'b1, 16, word(1'b1, 1'b0, 0, 16'hFFFF), 16);
        idle_cyc(16);
        step(1'b1, 1'b1, 17, word(1'b0, 1'b0, 2, 16'hFFFF), 17);
        idle_cyc(17);
        step(1'b1, 1'b1, 18, word(1'b0, 1'b0, 6, 16'hFFF0), 18);
        cid_in = 8'hF0; idle_cyc(18);
        step(1'b1, 1'b1, 19, word(1'b0, 1'b0, 7, 16'hFF00), 19);
        idle_cyc(19);

        phase = "R3 write and evaluation in the same cycle (random)";
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom_range(0, 3) != 0) d[19] = 1'b0;
            ext_in = 4'($urandom); pec_in = 8'($urandom); cnt_zero = 4'($urandom);
            seq_st = 4'(1 << $urandom_range(0, 3)); ssc_in = 8'($urandom);
            sac_in = 16'($urandom); arc_in = 8'($urandom); cid_in = 8'($urandom);
            vmid_in = 8'($urandom);
            step(($urandom_range(0, 2) != 0), ($urandom_range(0, 4) != 0),
                 $urandom_range(0, 31), d, $urandom_range(0, 31));
        end

        print_summary();
        $finish;
    end

endmodule